// File: doc/BRIEF.md
# Fuzzy Lookup Duty-Ratio PWM Controller

This block closes a voltage regulation loop around a switching converter without evaluating fuzzy rules at run time. A digitised reading of the converter output voltage arrives with a valid strobe. The block sorts the reading into one of 29 narrow voltage bins. A fixed table then turns the bin into a 7-bit defuzzified control code, and that code sets the duty ratio of a free-running PWM gate signal. The table is hard-coded, so its cost does not grow with the number of rules that produced it.

The reading is an unsigned count in units of 10 mV. The bins are 0.2 V (20 counts) wide and cover 5.2 V to 10.8 V. A high reading gives a low code, and a low code gives a high duty ratio. The bin that holds the 8.0 V setpoint sits in the middle of the table. The PWM period is 256 clocks. The compare value for a period is fixed at the moment the period starts.

Top module: `fuzzy_duty_pwm`

## Requirements
- R1: Synchronous reset forces `gate_o` low. It sets the bin to 15 (the setpoint bin, code 70). The first PWM pulse after reset is high for 103 clocks.
- R2: `bin_o` is 1 for any reading at or below 520. For a reading above 520 it is 2 + (reading − 521)/20, using integer division. Readings above 1080 are clamped to 29, so `bin_o` never leaves the range 1..29.
- R3: `code_o` shows the code for the current bin. From bin 1 up to bin 29 the codes are 120, 118, 116, 114, 111, 109, 106, 103, 101, 99, 98, 97, 96, 94, 70, 45, 43, 42, 41, 40, 38, 36, 33, 30, 28, 25, 23, 21, 20.
- R4: Each PWM pulse is high for 128 − floor(code × 92 / 256) consecutive clocks. Because of the minus sign, a higher code gives a shorter pulse.
- R5: The PWM period, measured from one rising edge of `gate_o` to the next, is 256 clocks.
- R6: A reading presented while `smp_valid` is low is ignored, and `bin_o` and `code_o` keep their values.
- R7: A new code that arrives in the middle of a period does not change the pulse in progress. It takes effect from the next period.
- R8: A valid sample updates `bin_o` and `code_o` on the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe that qualifies `smp_level` |
| smp_level | input | 11 | Output-voltage reading in units of 10 mV |
| bin_o | output | 5 | Current voltage bin (1..29) |
| code_o | output | 7 | Defuzzified code for the current bin |
| gate_o | output | 1 | PWM switch-gate drive |

## Verification
`bin_o` and `code_o` change one clock after the edge that captures a valid sample. The bench drives inputs on the falling edge and reads these outputs on the next falling edge. A new duty ratio appears only at the next period boundary, and `gate_o` is registered one more clock behind the counter. For that reason, the bench lets one full period pass after each new sample before it measures a pulse. It measures the pulse width from the rising edge of `gate_o` to the falling edge, and the period from one rising edge to the next, sampling on falling edges. The mid-period test changes the reading ten clocks into a pulse. It then checks that pulse against the old width and the following pulse against the new one.

// File: rtl/fuzzy_duty_pwm.sv
module fuzzy_duty_pwm #(
  parameter int SW         = 11,
  parameter int LO         = 520,
  parameter int STEP       = 20,
  parameter int NBINS      = 29,
  parameter int IW         = 5,
  parameter int CW         = 7,
  parameter int PW         = 8,
  parameter int SET_BIN    = 15,
  parameter int DUTY_OFS   = 128,
  parameter int DUTY_SLOPE = 92,
  parameter int DUTY_SH    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_level,
  output logic [IW-1:0] bin_o,
  output logic [CW-1:0] code_o,
  output logic          gate_o
);
  localparam int NTH = NBINS - 1;

  function automatic logic [CW-1:0] code_of(input logic [IW-1:0] b);
    case (b)
      5'd1:  code_of = 7'd120;
      5'd2:  code_of = 7'd118;
      5'd3:  code_of = 7'd116;
      5'd4:  code_of = 7'd114;
      5'd5:  code_of = 7'd111;
      5'd6:  code_of = 7'd109;
      5'd7:  code_of = 7'd106;
      5'd8:  code_of = 7'd103;
      5'd9:  code_of = 7'd101;
      5'd10: code_of = 7'd99;
      5'd11: code_of = 7'd98;
      5'd12: code_of = 7'd97;
      5'd13: code_of = 7'd96;
      5'd14: code_of = 7'd94;
      5'd16: code_of = 7'd45;
      5'd17: code_of = 7'd43;
      5'd18: code_of = 7'd42;
      5'd19: code_of = 7'd41;
      5'd20: code_of = 7'd40;
      5'd21: code_of = 7'd38;
      5'd22: code_of = 7'd36;
      5'd23: code_of = 7'd33;
      5'd24: code_of = 7'd30;
      5'd25: code_of = 7'd28;
      5'd26: code_of = 7'd25;
      5'd27: code_of = 7'd23;
      5'd28: code_of = 7'd21;
      5'd29: code_of = 7'd20;
      default: code_of = 7'd70;
    endcase
  endfunction

  function automatic logic [PW-1:0] duty_of(input logic [CW-1:0] c);
    int t;
    t = DUTY_OFS - ((int'(c) * DUTY_SLOPE) >>> DUTY_SH);
    return PW'(t);
  endfunction

  logic [NTH-1:0] over;
  logic [IW-1:0]  bin_new, bin_q;
  logic [PW-1:0]  cnt_q, cmp_q;
  logic           gate_q;

  for (genvar k = 0; k < NTH; k++) begin : g_thr
    assign over[k] = 32'(smp_level) > 32'(LO + STEP * k);
  end

  always_comb begin
    bin_new = IW'(1);
    for (int k = 0; k < NTH; k++) bin_new = bin_new + IW'(over[k]);
  end

  assign bin_o  = bin_q;
  assign code_o = code_of(bin_q);
  assign gate_o = gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= IW'(SET_BIN);
      cnt_q  <= '0;
      cmp_q  <= duty_of(code_of(IW'(SET_BIN)));
      gate_q <= 1'b0;
    end else begin
      if (smp_valid) bin_q <= bin_new;
      cnt_q  <= cnt_q + 1'b1;
      if (&cnt_q) cmp_q <= duty_of(code_o);
      gate_q <= cnt_q < cmp_q;
    end
  end
endmodule

module fuzzy_duty_pwm_chk #(
  parameter int SW = 11,
  parameter int IW = 5,
  parameter int NBINS = 29,
  parameter int HI = 1080
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [SW-1:0] smp_level,
  input logic [IW-1:0] bin_o,
  input logic          gate_o
);
  a_r1_reset_gate_low: assert property (@(posedge clk) rst |=> !gate_o);
  a_r2_bin_in_range: assert property (@(posedge clk) disable iff (rst)
    (bin_o >= IW'(1)) && (32'(bin_o) <= NBINS));
  a_r2_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && 32'(smp_level) > HI) |=> (32'(bin_o) == NBINS));
  a_r6_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(bin_o));
endmodule

bind fuzzy_duty_pwm fuzzy_duty_pwm_chk #(.SW(SW), .IW(IW), .NBINS(NBINS), .HI(LO + STEP * (NBINS - 1)))
  u_chk (.clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_level(smp_level),
         .bin_o(bin_o), .gate_o(gate_o));

// File: tb/fuzzy_duty_pwm_bench.sv
module fuzzy_duty_pwm_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [10:0] smp_level = '0;
  logic [4:0]  bin_o;
  logic [6:0]  code_o;
  logic        gate_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int codes[29] = '{120, 118, 116, 114, 111, 109, 106, 103, 101, 99, 98, 97, 96, 94, 70,
                    45, 43, 42, 41, 40, 38, 36, 33, 30, 28, 25, 23, 21, 20};

  fuzzy_duty_pwm u_fuzzy_duty_pwm (.clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_level(smp_level), .bin_o(bin_o), .code_o(code_o), .gate_o(gate_o));

  always #5 clk = ~clk;

  function automatic int exp_bin(input int lv);
    int b;
    if (lv <= 520) return 1;
    b = (lv - 521) / 20 + 2;
    return (b > 29) ? 29 : b;
  endfunction

  function automatic int exp_width(input int code);
    return 128 - (code * 92) / 256;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  task automatic send(input int lv, input logic v);
    smp_level = 11'(lv);
    smp_valid = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_rise();
    logic g;
    do begin
      g = gate_o;
      @(negedge clk);
    end while (!(!g && gate_o));
  endtask

  task automatic measure(output int w, output int per);
    int lo;
    wait_rise();
    w = 0;
    while (gate_o) begin w++; @(negedge clk); end
    lo = 0;
    while (!gate_o) begin lo++; @(negedge clk); end
    per = w + lo;
  endtask

  task automatic t_reset();
    int w, per;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gate low in reset", int'(gate_o), 0);
    chk("R1 bin after reset", int'(bin_o), 15);
    chk("R1 code after reset", int'(code_o), 70);
    rst = 1'b0;
    measure(w, per);
    chk("R1 first pulse width", w, 103);
    chk("R5 period", per, 256);
  endtask

  task automatic t_sweep();
    int w, per;
    for (int b = 1; b <= 29; b++) begin
      send(500 + 20 * b, 1'b1);
      chk($sformatf("R8 bin for bin %0d", b), int'(bin_o), b);
      chk($sformatf("R3 code for bin %0d", b), int'(code_o), codes[b-1]);
      wait_rise();
      measure(w, per);
      chk($sformatf("R4 width for bin %0d", b), w, exp_width(codes[b-1]));
      if (b == 29) chk("R5 period at low duty", per, 256);
    end
  endtask

  task automatic t_edges();
    int lvls[10] = '{0, 519, 520, 521, 540, 541, 779, 1080, 1081, 2047};
    foreach (lvls[i]) begin
      send(lvls[i], 1'b1);
      chk($sformatf("R2 bin for level %0d", lvls[i]), int'(bin_o), exp_bin(lvls[i]));
    end
  endtask

  task automatic t_invalid();
    int w, per;
    send(790, 1'b1);
    chk("R6 setup bin", int'(bin_o), 15);
    send(300, 1'b0);
    send(1500, 1'b0);
    chk("R6 bin held", int'(bin_o), 15);
    chk("R6 code held", int'(code_o), 70);
    wait_rise();
    measure(w, per);
    chk("R6 width held", w, exp_width(70));
  endtask

  task automatic t_midperiod();
    int w, lo;
    wait_rise();
    repeat (10) @(negedge clk);
    send(520, 1'b1);
    w = 11;
    while (gate_o) begin w++; @(negedge clk); end
    chk("R7 pulse in progress keeps old width", w, exp_width(70));
    lo = 0;
    while (!gate_o) begin lo++; @(negedge clk); end
    chk("R5 period across update", w + lo, 256);
    w = 0;
    while (gate_o) begin w++; @(negedge clk); end
    chk("R7 next pulse takes new width", w, exp_width(120));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_edges();
    t_invalid();
    t_midperiod();
    finish_run();
  end
endmodule